// File: doc/BRIEF.md
# Parallel Variable-Length Instruction Boundary Finder

This block accepts a byte stream of variable-length instructions one fixed-size chunk at a time and reports where the instructions begin. Each instruction is between 1 and 15 bytes long. It consists of a run of zero or more prefix bytes, one opcode byte, and a number of trailing operand bytes that the opcode fixes. The end of an instruction is only known after its prefixes have been scanned. For that reason a length pre-decoder is placed at every byte offset of the chunk, and each one assumes that its offset is an instruction start. All of them produce a candidate length in the same cycle.

A serial hop chain then starts at the known offset of the first instruction in the chunk. It follows each accepted length to the next start. Candidates at the offsets it skips are dropped. An instruction may run into the following chunk, so the block holds one chunk and decodes it once the next chunk has arrived. The amount by which the last instruction overhangs the chunk becomes the first start offset of the next chunk. If the chain lands on a candidate that cannot be decoded, the block flags a decode fault and stops tracking boundaries until a flush. A flush supplies a fresh start offset.

The chunk input and the result output each use a valid/ready handshake, so the consumer can stall the block.

Top module: `vlen_boundary_finder`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the first chunk is decoded from start offset 0.
- R2: The prefix bytes are 0x26, 0x2E, 0x66, 0xF2 and 0xF3. The opcode is the first byte that is not a prefix. Opcode bits [7:6] select the number of trailing bytes: 00 gives 0, 01 gives 1, 10 gives 2 and 11 gives 4. Length = prefix count + 1 + trailing bytes.
- R3: out_starts bit i is 1 exactly for the offsets i reached by hopping from the chunk's start offset by the decoded lengths. The result for a chunk is registered on the clock edge that accepts the following chunk.
- R4: For every marked offset i, out_lens[4*i+3:4*i] holds the decoded length of that instruction. The field is 0 at every unmarked offset.
- R5: When no fault occurs, out_carry equals the end position of the last instruction minus 16. That value is used as the start offset of the next chunk.
- R6: If the chain reaches a start whose length would exceed 15 bytes, or whose 15 bytes are all prefixes, out_fault is 1. In that case only the starts before it are marked and out_carry is 0. Every later result until a flush has out_fault 1, no marks and no lengths.
- R7: in_ready is 0 during flush and otherwise equals (not out_valid) or out_ready. While out_valid is 1 and out_ready is 0, all outputs hold their values.
- R8: A flush drops the held chunk and any pending result and clears the fault state. The next chunk accepted after the flush is decoded from flush_off.
- R9: A candidate at an offset the chain skips has no effect, even when it is undecodable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Restart boundary tracking |
| flush_off | input | 4 | First-instruction offset applied by a flush |
| in_valid | input | 1 | Chunk present on in_data |
| in_ready | output | 1 | Block accepts a chunk this cycle |
| in_data | input | 128 | Chunk bytes, byte i in bits [8*i+7:8*i] |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_starts | output | 16 | Instruction-start mark per byte offset |
| out_lens | output | 64 | 4-bit length per offset, nonzero only at starts |
| out_fault | output | 1 | Undecodable instruction reached or tracking lost |
| out_carry | output | 4 | Start offset of the next chunk |

## Verification
The assertions check on every cycle that a length field is nonzero exactly where a start is marked, that the carry stays below the maximum length, that a faulting result carries no offset, that a stalled result holds still, and that a flush empties the output. Only the bench scenarios can show that the marked starts are the true boundaries. To do this, the bench compares every result with a sequential byte-by-byte reference decoder running over random legal streams with random output stalls. The scenarios also cover a directed case with an undecodable candidate hidden at a skipped offset, a faulting start with its sticky aftermath, and flushes to nonzero offsets.

// File: rtl/vlbf_pkg.sv
package vlbf_pkg;

    localparam int DEF_CHUNK_BYTES = 16;
    localparam int DEF_MAX_LEN     = 15;

    typedef enum logic {
        TRK_SYNC = 1'b0,
        TRK_LOST = 1'b1
    } track_e;

    // Recognised prefix byte values.
    function automatic logic is_prefix(input logic [7:0] b);
        case (b)
            8'h26, 8'h2E, 8'h66, 8'hF2, 8'hF3: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

    // Operand bytes that follow an opcode, chosen by its top two bits.
    function automatic logic [2:0] tail_bytes(input logic [7:0] op);
        case (op[7:6])
            2'b00:   return 3'd0;
            2'b01:   return 3'd1;
            2'b10:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/vlbf_len_cand.sv
module vlbf_len_cand
    import vlbf_pkg::*;
#(
    parameter int MAX_LEN = DEF_MAX_LEN
) (
    input  logic [MAX_LEN*8-1:0]          win_i,
    output logic                          ok_o,
    output logic [$clog2(MAX_LEN+1)-1:0]  len_o
);
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    always_comb begin
        int         npfx;
        int         total;
        logic       scanning;
        logic [7:0] op;
        npfx     = 0;
        scanning = 1'b1;
        for (int k = 0; k < MAX_LEN; k++) begin
            if (scanning && is_prefix(win_i[k*8 +: 8])) begin
                npfx = npfx + 1;
            end else begin
                scanning = 1'b0;
            end
        end
        op = 8'h00;
        for (int k = 0; k < MAX_LEN; k++) begin
            if (k == npfx) begin
                op = win_i[k*8 +: 8];
            end
        end
        total = npfx + 1 + int'(tail_bytes(op));
        ok_o  = (npfx < MAX_LEN) && (total <= MAX_LEN);
        len_o = ok_o ? LEN_W'(total) : '0;
    end

endmodule

// File: rtl/vlbf_hop_chain.sv
module vlbf_hop_chain #(
    parameter int CHUNK_BYTES = 16,
    parameter int MAX_LEN     = 15
) (
    input  logic [$clog2(CHUNK_BYTES)-1:0]             start_i,
    input  logic [CHUNK_BYTES-1:0]                     ok_i,
    input  logic [CHUNK_BYTES*$clog2(MAX_LEN+1)-1:0]   len_i,
    output logic [CHUNK_BYTES-1:0]                     mark_o,
    output logic [CHUNK_BYTES*$clog2(MAX_LEN+1)-1:0]   lens_o,
    output logic                                       fault_o,
    output logic [$clog2(CHUNK_BYTES)-1:0]             carry_o
);
    localparam int OFF_W = $clog2(CHUNK_BYTES);
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    // Serial walk: each stage only fires when the running position equals
    // its own offset, then pushes the position forward by its length.
    always_comb begin
        int   nxt;
        logic halted;
        nxt     = int'(start_i);
        halted  = 1'b0;
        mark_o  = '0;
        lens_o  = '0;
        fault_o = 1'b0;
        for (int i = 0; i < CHUNK_BYTES; i++) begin
            if (!halted && nxt == i) begin
                if (ok_i[i]) begin
                    mark_o[i]                 = 1'b1;
                    lens_o[i*LEN_W +: LEN_W]  = len_i[i*LEN_W +: LEN_W];
                    nxt = i + int'(len_i[i*LEN_W +: LEN_W]);
                end else begin
                    fault_o = 1'b1;
                    halted  = 1'b1;
                end
            end
        end
        carry_o = fault_o ? '0 : OFF_W'(nxt - CHUNK_BYTES);
    end

endmodule

// File: rtl/vlen_boundary_finder.sv
module vlen_boundary_finder
    import vlbf_pkg::*;
#(
    parameter int CHUNK_BYTES = DEF_CHUNK_BYTES,
    parameter int MAX_LEN     = DEF_MAX_LEN
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      flush,
    input  logic [$clog2(CHUNK_BYTES)-1:0]            flush_off,
    input  logic                                      in_valid,
    output logic                                      in_ready,
    input  logic [CHUNK_BYTES*8-1:0]                  in_data,
    output logic                                      out_valid,
    input  logic                                      out_ready,
    output logic [CHUNK_BYTES-1:0]                    out_starts,
    output logic [CHUNK_BYTES*$clog2(MAX_LEN+1)-1:0]  out_lens,
    output logic                                      out_fault,
    output logic [$clog2(CHUNK_BYTES)-1:0]            out_carry
);
    localparam int OFF_W     = $clog2(CHUNK_BYTES);
    localparam int LEN_W     = $clog2(MAX_LEN + 1);
    localparam int WIN_BYTES = CHUNK_BYTES + MAX_LEN - 1;

    logic [CHUNK_BYTES*8-1:0] held_q;
    logic                     held_vld_q;
    logic [OFF_W-1:0]         start_q;
    track_e                   trk_q;

    logic [WIN_BYTES*8-1:0]       win;
    logic [CHUNK_BYTES-1:0]       cand_ok;
    logic [CHUNK_BYTES*LEN_W-1:0] cand_len;
    logic [CHUNK_BYTES-1:0]       sel_mark;
    logic [CHUNK_BYTES*LEN_W-1:0] sel_lens;
    logic                         sel_fault;
    logic [OFF_W-1:0]             sel_carry;
    logic                         accept;

    assign in_ready = !flush && (!out_valid || out_ready);
    assign accept   = in_valid && in_ready;

    // Held chunk in the low bytes, lookahead from the arriving chunk above.
    assign win = {in_data[(MAX_LEN-1)*8-1:0], held_q};

    for (genvar g = 0; g < CHUNK_BYTES; g++) begin : g_cand
        vlbf_len_cand #(.MAX_LEN(MAX_LEN)) u_cand (
            .win_i (win[g*8 +: MAX_LEN*8]),
            .ok_o  (cand_ok[g]),
            .len_o (cand_len[g*LEN_W +: LEN_W])
        );
    end

    vlbf_hop_chain #(.CHUNK_BYTES(CHUNK_BYTES), .MAX_LEN(MAX_LEN)) u_chain (
        .start_i (start_q),
        .ok_i    (cand_ok),
        .len_i   (cand_len),
        .mark_o  (sel_mark),
        .lens_o  (sel_lens),
        .fault_o (sel_fault),
        .carry_o (sel_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q     <= '0;
            held_vld_q <= 1'b0;
            start_q    <= '0;
            trk_q      <= TRK_SYNC;
            out_valid  <= 1'b0;
            out_starts <= '0;
            out_lens   <= '0;
            out_fault  <= 1'b0;
            out_carry  <= '0;
        end else if (flush) begin
            held_vld_q <= 1'b0;
            out_valid  <= 1'b0;
            start_q    <= flush_off;
            trk_q      <= TRK_SYNC;
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (accept) begin
                held_q     <= in_data;
                held_vld_q <= 1'b1;
                if (held_vld_q) begin
                    out_valid <= 1'b1;
                    if (trk_q == TRK_LOST) begin
                        out_starts <= '0;
                        out_lens   <= '0;
                        out_fault  <= 1'b1;
                        out_carry  <= '0;
                    end else begin
                        out_starts <= sel_mark;
                        out_lens   <= sel_lens;
                        out_fault  <= sel_fault;
                        out_carry  <= sel_carry;
                        start_q    <= sel_carry;
                        if (sel_fault) begin
                            trk_q <= TRK_LOST;
                        end
                    end
                end
            end
        end
    end

    // R7: a stalled result keeps every field
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !flush |=>
            out_valid && $stable(out_starts) && $stable(out_lens)
            && $stable(out_fault) && $stable(out_carry));

    // R8: flush leaves no pending result
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid);

    // R5: carry into the next chunk is shorter than one instruction
    a_r5_carry_range: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_fault |-> int'(out_carry) < MAX_LEN);

    // R6: a faulting result offers no next offset
    a_r6_fault_no_carry: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_fault |-> out_carry == '0);

    // R3: a healthy chunk always contains at least one start
    a_r3_some_start: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_fault |-> out_starts != '0);

    for (genvar g = 0; g < CHUNK_BYTES; g++) begin : g_lenchk
        // R4: a length field is nonzero exactly where a start is marked
        a_r4_len_at_start: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> ((out_lens[g*LEN_W +: LEN_W] != '0) == out_starts[g]));
    end

endmodule

// File: tb/vlen_boundary_finder_test.sv
module vlen_boundary_finder_test;
    localparam int CLK_PERIOD = 10;
    localparam int CHUNK = 16;
    localparam int MLEN  = 15;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         flush = 1'b0;
    logic [3:0]   flush_off = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [15:0]  out_starts;
    logic [63:0]  out_lens;
    logic         out_fault;
    logic [3:0]   out_carry;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlen_boundary_finder uut (
        .clk(clk), .rst(rst), .flush(flush), .flush_off(flush_off),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_starts(out_starts),
        .out_lens(out_lens), .out_fault(out_fault), .out_carry(out_carry)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] mem [0:4095];
    logic [15:0] q_starts [$];
    logic [63:0] q_lens [$];
    logic        q_fault [$];
    logic [3:0]  q_carry [$];
    int chunk_idx, n_chunks, faults_seen, outs_seen;
    bit stall_prev = 0;
    logic [15:0] sv_starts;
    logic [63:0] sv_lens;
    logic        sv_fault;
    logic [3:0]  sv_carry;
    logic [15:0] first_starts;
    logic [63:0] first_lens;
    logic [3:0]  first_carry;

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit pfx(input logic [7:0] b);
        return b == 8'h26 || b == 8'h2E || b == 8'h66 || b == 8'hF2 || b == 8'hF3;
    endfunction

    // Sequential reference: length of the instruction at byte address base, 0 if undecodable.
    function automatic int ref_len(input int base);
        int p = 0;
        int t;
        int l;
        while (p < MLEN && pfx(mem[base + p])) p++;
        if (p == MLEN) return 0;
        case (mem[base + p][7:6])
            2'b00: t = 0;
            2'b01: t = 1;
            2'b10: t = 2;
            default: t = 4;
        endcase
        l = p + 1 + t;
        return (l > MLEN) ? 0 : l;
    endfunction

    task automatic build_expected(input int n, input int start);
        int pos = start;
        bit lost = 0;
        for (int c = 0; c < n - 1; c++) begin
            logic [15:0] m = '0;
            logic [63:0] ls = '0;
            bit f = lost;
            if (!lost) begin
                while (pos < CHUNK) begin
                    int l = ref_len(c * CHUNK + pos);
                    if (l == 0) begin
                        f = 1; lost = 1;
                        break;
                    end
                    m[pos] = 1'b1;
                    ls[pos*4 +: 4] = 4'(l);
                    pos += l;
                end
                if (!f) pos -= CHUNK;
            end
            q_starts.push_back(m);
            q_lens.push_back(ls);
            q_fault.push_back(f);
            q_carry.push_back(f ? 4'd0 : 4'(pos));
        end
    endtask

    task automatic randomize_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    endtask

    task automatic gen_fill(input int from, input int upto, input int maxp);
        int pos = from;
        while (pos < upto) begin
            int code = $urandom_range(3);
            int t = (code == 3) ? 4 : code;
            int pmax = (maxp < 14 - t) ? maxp : 14 - t;
            int p = $urandom_range(pmax);
            logic [7:0] op;
            logic [7:0] pset [5] = '{8'h26, 8'h2E, 8'h66, 8'hF2, 8'hF3};
            do op = {2'(code), 6'($urandom_range(63))}; while (pfx(op));
            for (int k = 0; k < p; k++) mem[pos + k] = pset[$urandom_range(4)];
            mem[pos + p] = op;
            for (int k = 0; k < t; k++) mem[pos + p + 1 + k] = 8'($urandom);
            pos += p + 1 + t;
        end
    endtask

    task automatic compare_pop();
        if (q_starts.size() == 0) begin
            chk(0, "R3", "unexpected output", 64'(out_starts), 0);
        end else begin
            logic [15:0] es = q_starts.pop_front();
            logic [63:0] el = q_lens.pop_front();
            logic        ef = q_fault.pop_front();
            logic [3:0]  ec = q_carry.pop_front();
            chk(out_starts == es, "R3", "start marks", 64'(out_starts), 64'(es));
            chk(out_lens == el, "R4", "lengths", out_lens, el);
            chk(out_fault == ef, "R6", "fault", 64'(out_fault), 64'(ef));
            chk(out_carry == ec, "R5", "carry", 64'(out_carry), 64'(ec));
        end
        if (outs_seen == 0) begin
            first_starts = out_starts;
            first_lens = out_lens;
            first_carry = out_carry;
        end
        outs_seen++;
        if (out_fault) faults_seen++;
    endtask

    task automatic cycle(input int rdy_pct);
        @(negedge clk);
        out_ready = ($urandom_range(99) < rdy_pct);
        if (chunk_idx < n_chunks) begin
            in_valid = 1'b1;
            for (int b = 0; b < CHUNK; b++) in_data[b*8 +: 8] = mem[chunk_idx * CHUNK + b];
        end else begin
            in_valid = 1'b0;
        end
        #1;
        if (stall_prev) begin
            chk(out_valid && out_starts == sv_starts && out_lens == sv_lens &&
                out_fault == sv_fault && out_carry == sv_carry,
                "R7", "held during stall", out_lens, sv_lens);
        end
        stall_prev = out_valid && !out_ready;
        sv_starts = out_starts; sv_lens = out_lens;
        sv_fault = out_fault; sv_carry = out_carry;
        if (out_valid && out_ready) compare_pop();
        if (in_valid && in_ready) chunk_idx++;
    endtask

    task automatic run_stream(input int n, input int start, input int rdy);
        int guard = 0;
        build_expected(n, start);
        chunk_idx = 0; n_chunks = n; faults_seen = 0; outs_seen = 0;
        while (chunk_idx < n) cycle(rdy);
        while (q_starts.size() != 0 && guard < 100) begin
            cycle(100);
            guard++;
        end
        chk(q_starts.size() == 0, "R3", "missing outputs", 64'(q_starts.size()), 0);
    endtask

    task automatic flush_to(input logic [3:0] off);
        @(negedge clk);
        flush = 1'b1; flush_off = off; in_valid = 1'b0; out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R7", "ready low during flush", 64'(in_ready), 0);
        @(negedge clk);
        flush = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R8", "no result after flush", 64'(out_valid), 0);
        stall_prev = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 1);

        // R1/R3/R4/R5/R7: random stream from the reset offset, random stalls
        randomize_mem();
        gen_fill(0, 60 * CHUNK + 32, 3);
        run_stream(60, 0, 70);

        // R8/R5: flush to a nonzero offset, long prefix runs
        flush_to(4'd7);
        randomize_mem();
        gen_fill(7, 60 * CHUNK + 32, 10);
        run_stream(60, 7, 50);

        // R9/R2: undecodable candidate at a skipped offset
        flush_to(4'd0);
        randomize_mem();
        mem[0] = 8'hC1;
        for (int k = 1; k <= 4; k++) mem[k] = 8'h66;
        for (int k = 5; k <= 14; k++) mem[k] = 8'h2E;
        mem[15] = 8'hC5;
        for (int k = 16; k <= 19; k++) mem[k] = 8'h00;
        gen_fill(20, 6 * CHUNK + 32, 4);
        run_stream(6, 0, 100);
        chk(faults_seen == 0, "R9", "skipped bad candidate faulted", 64'(faults_seen), 0);
        chk(first_lens[3:0] == 4'd5, "R2", "length at offset 0", 64'(first_lens[3:0]), 5);
        chk(first_lens[23:20] == 4'd15, "R2", "length at offset 5", 64'(first_lens[23:20]), 15);
        chk(first_starts == 16'h0021, "R3", "directed marks", 64'(first_starts), 64'h21);
        chk(first_carry == 4'd4, "R5", "directed carry", 64'(first_carry), 4);

        // R6: reached start with fifteen prefixes, then sticky fault
        flush_to(4'd2);
        randomize_mem();
        mem[2] = 8'h05;
        for (int k = 3; k <= 17; k++) mem[k] = 8'hF3;
        gen_fill(18, 4 * CHUNK + 32, 3);
        run_stream(4, 2, 60);
        chk(faults_seen == 3, "R6", "sticky fault count", 64'(faults_seen), 3);
        chk(first_starts == 16'h0004, "R6", "starts before fault", 64'(first_starts), 4);

        // R8: flush clears the lost state
        flush_to(4'd0);
        randomize_mem();
        gen_fill(0, 10 * CHUNK + 32, 6);
        run_stream(10, 0, 80);
        chk(faults_seen == 0, "R8", "fault cleared by flush", 64'(faults_seen), 0);

        finish_run();
    end

endmodule